// File: doc/BRIEF.md
# Calendar Time-of-Day Counter with Start-on-Write

This block keeps calendar time as seven packed-BCD fields: seconds, minutes, hours, a weekday index, day of month, month and a two-digit year. A clock-enable pulse from the 32.768 kHz domain drives an internal prescaler, and each time the prescaler completes a full second the seconds field advances. Carries then ripple upward through the fields as needed. The day-of-month rollover follows the real month length, including February in leap years. The hour field can run in 24-hour form or in 12-hour form with a PM flag.

After a cold reset the fields hold their reset values and do not move. Counting begins only when software writes one of the seven time registers. Software loads and inspects the fields through a byte-wide register port: writes take effect at a clock edge, and reads are combinational on a separate read address. A one-cycle `sec_tick` output reports each advance of the seconds field, for use by a downstream alarm comparator.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the registers read sec 00h, min 00h, hour 80h (24-hour, hour 00), weekday 00h, date 01h, month 01h, year 00h. While no time register has been written, the fields stay unchanged and `sec_tick` stays low, whatever `osc_en` does.
- R2: A write to any address 0..6 starts counting. A write to address 7 is ignored: it does not start counting, it changes no field, and address 7 always reads 00h.
- R3: Once counting, the seconds field advances exactly once every `TICKS_PER_SEC` clock cycles that have `osc_en` high (default 32768). The new value is readable after the clock edge that samples the last of those pulses.
- R4: A write to a time register loads that field at the clock edge and restarts the prescaler. It also cancels any advance in that same cycle. A full `TICKS_PER_SEC` enable pulses must follow before the next advance.
- R5: `sec_tick` is high for exactly the first cycle in which an advanced seconds value is readable. A register write never raises it.
- R6: Seconds and minutes count 00..59 in BCD. Seconds 59 wraps to 00 and increments minutes. Minutes 59 wraps to 00 and increments hours.
- R7: With hour bit 7 = 1 (24-hour form, bits 5:0 BCD 00..23), hour 23 wraps to 00 and produces the day carry.
- R8: With hour bit 7 = 0 (12-hour form), bits 4:0 hold BCD 01..12 and bit 5 is the PM flag. The sequence runs 12, 01..11. Hour 11 goes to 12 and toggles the PM flag (11h becomes 32h, 31h becomes 12h). Only the step from 11 PM to 12 AM produces the day carry.
- R9: On a day carry, the date increments. After the last day of the month it returns to 01 and the month increments. Months 4, 6, 9 and 11 have 30 days and the other months have 31, except February. February has 29 days when the year is divisible by 4 and 28 otherwise. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R10: The weekday index increments on every day carry and wraps from 6 to 0.
- R11: Register map: 0 seconds (bits 6:0), 1 minutes (6:0), 2 hours (7:0, bit 6 always 0), 3 weekday (2:0), 4 date (5:0), 5 month (4:0), 6 year (7:0). Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; models a full loss of power |
| osc_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| sec_tick | output | 1 | One-cycle pulse when seconds advance |

## Verification
The embedded assertions check the following on every cycle:
- the fields stay frozen before the first write;
- a seconds write lands one edge later;
- the seconds field stays in BCD range;
- `sec_tick` is a single-cycle pulse and coincides with a changed seconds value;
- the wraps of hours, year and weekday, the 12-hour PM toggle, and the date-to-month rollover.

Only the bench scenarios can show the following:
- the exact prescaler count between advances, after a write lands mid-second;
- the length of each month, including leap and non-leap February;
- complete ripple chains such as 31 Dec 99 at 11:59:59 PM;
- that an address-7 write neither starts counting nor disturbs any field.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int unsigned REG_AW   = 3;
   localparam int unsigned REG_DW   = 8;
   localparam int unsigned NUM_FLDS = 7;

   typedef enum logic [REG_AW-1:0] {
      FLD_SEC   = 3'd0,
      FLD_MIN   = 3'd1,
      FLD_HOUR  = 3'd2,
      FLD_WDAY  = 3'd3,
      FLD_DATE  = 3'd4,
      FLD_MONTH = 3'd5,
      FLD_YEAR  = 3'd6,
      FLD_NONE  = 3'd7
   } fld_idx_e;

   // increment one packed-BCD byte (valid BCD input assumed)
   function automatic logic [7:0] bcd_next(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // two-digit BCD year divisible by four: (10*t + u) mod 4 == (2*t + u) mod 4
   function automatic logic year_is_leap(input logic [7:0] y);
      logic [1:0] r;
      r = {y[4], 1'b0} + y[1:0];
      return (r == 2'd0);
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return year_is_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic logic [7:0] fld_first(input int unsigned g);
      case (g)
         4, 5:    return 8'h01;
         2:       return 8'h80;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] fld_mask(input int unsigned g);
      case (g)
         0, 1:    return 8'h7F;
         2:       return 8'hBF;
         3:       return 8'h07;
         4:       return 8'h3F;
         5:       return 8'h1F;
         default: return 8'hFF;
      endcase
   endfunction

endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
   parameter int unsigned TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_en,
   input  logic run,
   input  logic clr,
   output logic done
);

   initial begin : chk_ticks
      assert (TICKS_PER_SEC >= 1)
         else $error("TICKS_PER_SEC must be at least 1");
   end

   generate
      if (TICKS_PER_SEC == 1) begin : g_direct
         assign done = run && osc_en && !clr;
      end else begin : g_count
         localparam int unsigned CW = $clog2(TICKS_PER_SEC);
         localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
         logic [CW-1:0] cnt_q;

         assign done = run && osc_en && !clr && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (clr || !run)     cnt_q <= '0;
            else if (osc_en)          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
         end

         // R4: a write restarts the count from zero
         assert_clr_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (cnt_q == '0));
      end
   endgenerate

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
   parameter logic [7:0] FIRST = 8'h00,
   parameter logic [7:0] MASK  = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld,
   input  logic [7:0] ld_val,
   input  logic       inc,
   input  logic [7:0] last_val,
   output logic [7:0] val,
   output logic       at_max
);
   import rtc_cal_pkg::*;

   assign at_max = (val >= last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val <= FIRST;
      else if (ld)   val <= ld_val & MASK;
      else if (inc)  val <= at_max ? FIRST : bcd_next(val);
   end

   // R6/R9/R10: a wrap always returns to the first value of the range
   assert_wrap_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && at_max) |=> (val == FIRST));

endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld,
   input  logic [7:0] ld_val,
   input  logic       inc,
   output logic [7:0] val,
   output logic       at_max
);
   import rtc_cal_pkg::*;

   logic       fmt24;
   logic       pm;
   logic [4:0] hr12;
   logic [7:0] nxt;
   logic [7:0] t;

   assign fmt24 = val[7];
   assign pm    = val[5];
   assign hr12  = val[4:0];

   always_comb begin
      t = 8'h00;
      if (fmt24) begin
         at_max = (val[5:0] >= 6'h23);
         t      = bcd_next({2'b00, val[5:0]});
         nxt    = at_max ? 8'h80 : {2'b10, t[5:0]};
      end else begin
         at_max = pm && (hr12 == 5'h11);
         if (hr12 >= 5'h12)      nxt = {2'b00, pm, 5'h01};
         else if (hr12 == 5'h11) nxt = {2'b00, ~pm, 5'h12};
         else begin
            t   = bcd_next({3'b000, hr12});
            nxt = {2'b00, pm, t[4:0]};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val <= 8'h80;
      else if (ld)  val <= ld_val & fld_mask(2);
      else if (inc) val <= nxt;
   end

   // R7: 24-hour form wraps 23 -> 00
   assert_h24_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && fmt24 && at_max) |=> (val == 8'h80));

   // R8: leaving hour 11 in 12-hour form toggles the PM flag
   assert_h12_pm_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld && !fmt24 && hr12 == 5'h11) |=> (val[5] != $past(val[5])));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
   parameter int unsigned TICKS_PER_SEC = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_en,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [2:0] rd_addr,
   output logic [7:0] rd_data,
   output logic       sec_tick
);
   import rtc_cal_pkg::*;

   localparam int unsigned NF = NUM_FLDS;

   logic [7:0]    fld_q [0:NF];
   logic [7:0]    last_v [0:NF-1];
   logic [NF-1:0] ld;
   logic [NF-1:0] inc;
   logic [NF-1:0] at_max;
   logic [NF-1:0] cy;
   logic          wr_hit;
   logic          running_q;
   logic          adv;

   assign wr_hit = wr_en && (wr_addr != FLD_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      running_q <= 1'b0;
      else if (wr_hit) running_q <= 1'b1;
   end

   rtc_sec_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .osc_en (osc_en),
      .run    (running_q),
      .clr    (wr_hit),
      .done   (adv)
   );

   // carry chain: sec -> min -> hour -> {weekday, date} -> month -> year
   assign cy  = inc & at_max;
   assign inc[FLD_SEC]   = adv;
   assign inc[FLD_MIN]   = cy[FLD_SEC];
   assign inc[FLD_HOUR]  = cy[FLD_MIN];
   assign inc[FLD_WDAY]  = cy[FLD_HOUR];
   assign inc[FLD_DATE]  = cy[FLD_HOUR];
   assign inc[FLD_MONTH] = cy[FLD_DATE];
   assign inc[FLD_YEAR]  = cy[FLD_MONTH];

   assign last_v[FLD_SEC]   = 8'h59;
   assign last_v[FLD_MIN]   = 8'h59;
   assign last_v[FLD_HOUR]  = 8'h00;
   assign last_v[FLD_WDAY]  = 8'h06;
   assign last_v[FLD_DATE]  = month_len(fld_q[FLD_MONTH], fld_q[FLD_YEAR]);
   assign last_v[FLD_MONTH] = 8'h12;
   assign last_v[FLD_YEAR]  = 8'h99;

   generate
      for (genvar g = 0; g < NF; g++) begin : g_fld
         assign ld[g] = wr_en && (wr_addr == 3'(g));
         if (g == FLD_HOUR) begin : g_hour
            rtc_hour_field u_hour (
               .clk    (clk),
               .rst_n  (rst_n),
               .ld     (ld[g]),
               .ld_val (wr_data),
               .inc    (inc[g]),
               .val    (fld_q[g]),
               .at_max (at_max[g])
            );
         end else begin : g_plain
            rtc_bcd_field #(.FIRST(fld_first(g)), .MASK(fld_mask(g))) u_cnt (
               .clk      (clk),
               .rst_n    (rst_n),
               .ld       (ld[g]),
               .ld_val   (wr_data),
               .inc      (inc[g]),
               .last_val (last_v[g]),
               .val      (fld_q[g]),
               .at_max   (at_max[g])
            );
         end
      end
   endgenerate

   assign fld_q[NF] = 8'h00;
   assign rd_data   = fld_q[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sec_tick <= 1'b0;
      else        sec_tick <= adv;
   end

   // R1/R2: frozen until a time register is written
   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_q && !wr_hit) |=> ($stable(fld_q[FLD_SEC]) && !sec_tick));

   // R4: a seconds write lands at the next edge
   assert_sec_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ld[FLD_SEC] |=> (fld_q[FLD_SEC] == ($past(wr_data) & 8'h7F)));

   // R5: the tick coincides with a changed seconds value
   assert_tick_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> (fld_q[FLD_SEC] != $past(fld_q[FLD_SEC])));

   // R5: a write never raises the tick
   assert_tick_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> !sec_tick);

   generate
      if (TICKS_PER_SEC > 1) begin : g_tick_chk
         assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
            sec_tick |=> !sec_tick);
      end
   endgenerate

   // R6: seconds stay valid BCD below 60
   assert_sec_bcd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fld_q[FLD_SEC][3:0] <= 4'd9) && (fld_q[FLD_SEC] <= 8'h59));

   // R9: end of month returns date to 01 and moves the month
   assert_date_roll_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cy[FLD_DATE] |=> ((fld_q[FLD_DATE] == 8'h01) && (fld_q[FLD_MONTH] != $past(fld_q[FLD_MONTH]))));

   // R9: year 99 wraps to 00
   assert_year_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cy[FLD_YEAR] |=> (fld_q[FLD_YEAR] == 8'h00));

   // R10: weekday 6 wraps to 0
   assert_wday_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cy[FLD_WDAY] |=> (fld_q[FLD_WDAY] == 8'h00));

endmodule

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;

   localparam int T = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       sec_tick;

   always #5 clk = ~clk;

   rtc_calendar #(.TICKS_PER_SEC(T)) u_rtc_calendar (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .sec_tick(sec_tick)
   );

   int n_run = 0, n_fail = 0;
   bit done_flag = 0;

   // reference model in binary
   int  m_s, m_m, m_h, m_w, m_d, m_mo, m_y;
   bit  m_f24, m_run, m_tick;
   int  m_pc;

   function automatic int b2i(input logic [7:0] v);
      return v[7:4] * 10 + v[3:0];
   endfunction
   function automatic logic [7:0] i2b(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction
   function automatic int dim(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction
   function automatic logic [7:0] enc(input int a);
      int h12;
      case (a)
         0: return i2b(m_s);
         1: return i2b(m_m);
         2: begin
            if (m_f24) return {2'b10, i2b(m_h)[5:0]};
            h12 = (m_h % 12 == 0) ? 12 : m_h % 12;
            return {2'b00, (m_h >= 12), i2b(h12)[4:0]};
         end
         3: return i2b(m_w);
         4: return i2b(m_d);
         5: return i2b(m_mo);
         6: return i2b(m_y);
         default: return 8'h00;
      endcase
   endfunction
   function automatic string tag_of(input int a);
      case (a)
         0, 1: return "R6";
         2: return m_f24 ? "R7" : "R8";
         3: return "R10";
         4, 5, 6: return "R9";
         default: return "R2/R11";
      endcase
   endfunction

   task automatic model_reset();
      m_s = 0; m_m = 0; m_h = 0; m_w = 0; m_d = 1; m_mo = 1; m_y = 0;
      m_f24 = 1; m_run = 0; m_tick = 0; m_pc = 0;
   endtask

   task automatic model_advance();
      m_s++;
      if (m_s == 60) begin
         m_s = 0; m_m++;
         if (m_m == 60) begin
            m_m = 0; m_h++;
            if (m_h == 24) begin
               m_h = 0; m_w = (m_w + 1) % 7; m_d++;
               if (m_d > dim(m_mo, m_y)) begin
                  m_d = 1; m_mo++;
                  if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
               end
            end
         end
      end
   endtask

   task automatic model_write(input int a, input logic [7:0] d);
      int h12;
      case (a)
         0: m_s = b2i(d & 8'h7F);
         1: m_m = b2i(d & 8'h7F);
         2: begin
            m_f24 = d[7];
            if (d[7]) m_h = b2i({2'b00, d[5:0]});
            else begin
               h12 = b2i({3'b000, d[4:0]});
               m_h = (h12 % 12) + (d[5] ? 12 : 0);
            end
         end
         3: m_w = b2i(d & 8'h07);
         4: m_d = b2i(d & 8'h3F);
         5: m_mo = b2i(d & 8'h1F);
         6: m_y = b2i(d);
         default: ;
      endcase
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, model the edge, sample at next negedge
   task automatic cycle(input bit osc, input bit we, input int a, input logic [7:0] d);
      osc_en = osc; wr_en = we; wr_addr = 3'(a); wr_data = d;
      m_tick = 0;
      if (we && a <= 6) begin
         model_write(a, d); m_pc = 0; m_run = 1;
      end else if (m_run && osc) begin
         m_pc++;
         if (m_pc == T) begin m_pc = 0; model_advance(); m_tick = 1; end
      end
      @(posedge clk);
      @(negedge clk);
      wr_en = 0; osc_en = 0;
      check(sec_tick == m_tick, "R3/R5", "sec_tick", {7'd0, sec_tick}, {7'd0, m_tick});
      rd_addr = 3'd0; #1;
      check(rd_data == enc(0), "R3/R4", "seconds", rd_data, enc(0));
   endtask

   task automatic check_all();
      for (int a = 0; a < 8; a++) begin
         rd_addr = 3'(a); #1;
         check(rd_data == enc(a), tag_of(a), $sformatf("reg %0d", a), rd_data, enc(a));
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 0, 8'h00);
   endtask

   task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                           input logic [7:0] y);
      cycle(1'b1, 1'b1, 6, y);
      cycle(1'b1, 1'b1, 5, mo);
      cycle(1'b1, 1'b1, 4, d);
      cycle(1'b1, 1'b1, 3, w);
      cycle(1'b1, 1'b1, 2, h);
      cycle(1'b1, 1'b1, 1, mi);
      cycle(1'b1, 1'b1, 0, s);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         n_fail++;
         $display("FAIL watchdog: got hung expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values, then frozen while unwritten
      check_all();
      run(3 * T + 5);
      check_all();

      // R2: address 7 write neither starts counting nor changes fields
      cycle(1'b1, 1'b1, 7, 8'h55);
      run(2 * T);
      check_all();

      // R2/R4: first real write starts counting; full second before advance
      cycle(1'b1, 1'b1, 0, 8'h57);
      run(3 * T);
      check_all();

      // R4: write mid-second restarts prescaler
      run(2);
      cycle(1'b1, 1'b1, 1, 8'h42);
      run(T + 1);
      check_all();

      // R7/R9/R10: leap February 28 -> 29, 24-hour midnight
      set_time(8'h58, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
      run(2 * T + 1);
      check_all();
      // R9: leap Feb 29 -> Mar 01
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
      run(T);
      check_all();
      // R9: non-leap Feb 28 -> Mar 01
      set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
      run(T);
      check_all();
      // R9: 30-day month
      set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 8'h10);
      run(T);
      check_all();

      // R8: 11 AM -> 12 PM
      set_time(8'h59, 8'h59, 8'h11, 8'h00, 8'h15, 8'h07, 8'h05);
      run(T);
      check_all();
      // R8: 12 PM -> 01 PM
      set_time(8'h59, 8'h59, 8'h32, 8'h00, 8'h15, 8'h07, 8'h05);
      run(T);
      check_all();
      // R8/R9/R10: 11 PM, Dec 31 99, weekday 6 -> full ripple
      set_time(8'h59, 8'h59, 8'h31, 8'h06, 8'h31, 8'h12, 8'h99);
      run(T + 2);
      check_all();
      // R7: 24-hour with no day carry at 22 -> 23
      set_time(8'h59, 8'h59, 8'hA2, 8'h05, 8'h10, 8'h01, 8'h50);
      run(T);
      check_all();

      // R3: irregular osc_en, random valid writes
      for (int i = 0; i < 4000; i++) begin
         bit osc, we;
         int a;
         logic [7:0] d;
         osc = ($urandom % 4) != 0;
         we  = ($urandom % 40) == 0;
         a   = 0; d = 8'h00;
         if (we) begin
            case ($urandom % 5)
               0: begin a = 0; d = i2b($urandom % 60); end
               1: begin a = 1; d = i2b($urandom % 60); end
               2: begin
                  a = 2;
                  if ($urandom % 2) d = {2'b10, i2b($urandom % 24)[5:0]};
                  else d = {2'b00, 1'($urandom % 2), i2b(1 + $urandom % 12)[4:0]};
               end
               3: begin a = 3; d = i2b($urandom % 7); end
               default: begin a = 7; d = 8'($urandom); end
            endcase
         end
         cycle(osc, we, a, d);
         if (i % 250 == 249) check_all();
      end
      check_all();

      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule